// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog peripheral on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. A counter runs down from a programmable reload value. It steps either on a 1 MHz tick taken from an internal prescaler or on every bus clock. Software keeps the counter from expiring by writing a 16-bit key to the restart register. The key must match exactly; any other value leaves the counter alone.

A timeout happens when the counter sits at zero on an enabled tick. The counter then reloads itself and keeps running. Depending on the control bits, a timeout does any of the following:
- sends a one-cycle reset request to one of three reset domains;
- sends a one-cycle external-signal request;
- raises a sticky interrupt;
- latches an alternate-boot state that swaps the two chip-select lines between the flash controller and the flash devices.

A write to the clear-status register undoes the latched state. The reset networks, the flash controller and the pulse shaping sit outside the block and only see the strobes.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter and reload registers hold RST_RELOAD, the control and status registers read 0, all strobes and the interrupt are low, and the chip selects pass straight through.
- R2: A write of exactly 32'h0000_4755 to the restart register (offset 0x08) loads the counter from the reload register, even when the counter is disabled. A write of any other value there leaves the counter unchanged.
- R3: While control bit 0 is set, the counter decrements by one on each selected tick. A tick that finds the counter at zero is a timeout: the counter reloads. After a restart with reload N, the first timeout strobe appears N+1 ticks after the enable is in effect.
- R4: On a timeout with control bit 1 set, exactly one one-cycle reset strobe fires, chosen by control bits 6:5: 00 and 11 select the SoC strobe, 01 the full-chip strobe, 10 the CPU strobe. Control bit 3 gives a one-cycle external request on the same cycle.
- R5: A timeout with control bit 2 set raises irq_o. irq_o stays high until a clear-status write, and it shows as status bit 2.
- R6: Any timeout sets status bit 0. A timeout with control bit 7 set also sets status bit 1, and while bit 1 is set the chip-select outputs are swapped (cs0_n_o follows cs1_n_i, and cs1_n_o follows cs0_n_i).
- R7: A write to the clear-status register (offset 0x14) with bit 0 set clears status bits 2:0 and restores the straight chip-select mapping. A write there with bit 0 clear has no effect.
- R8: Clearing control bit 0 freezes the counter. Setting it again resumes the count from the frozen value.
- R9: With control bit 4 set, the counter steps once every CLK_DIV bus clocks. With it clear, the counter steps on every bus clock.
- R10: The registers are at these offsets: counter at 0x00 (read-only, writes ignored), reload at 0x04, control at 0x0C (bits 7:0 stored, upper bits read 0), status at 0x10. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Sticky timeout interrupt |
| rst_soc_o | output | 1 | One-cycle SoC reset request |
| rst_chip_o | output | 1 | One-cycle full-chip reset request |
| rst_cpu_o | output | 1 | One-cycle CPU reset request |
| ext_req_o | output | 1 | One-cycle external signal request |
| cs0_n_i | input | 1 | Chip select 0 from the flash controller |
| cs1_n_i | input | 1 | Chip select 1 from the flash controller |
| cs0_n_o | output | 1 | Chip select to flash device 0 |
| cs1_n_o | output | 1 | Chip select to flash device 1 |

## Verification
The hardest state to reach from the ports is the latched alternate-boot swap, together with the exact cycle on which a timeout strobe appears. Both depend on the counter actually expiring. The bench therefore runs in the tick-every-clock mode and sweeps small reload values, so every expiry lands a few cycles after the enable write and its cycle can be predicted. It then stops the counter, sweeps all four chip-select input patterns while the swap is held, and checks the clear write both without and with bit 0 set. The prescaled mode is checked separately by how far the counter falls over a whole number of prescaler periods, which does not depend on the prescaler phase.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RESTART = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLEAR   = 8'h14;

  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;

  typedef enum logic [1:0] {
    TGT_SOC     = 2'b00,
    TGT_CHIP    = 2'b01,
    TGT_CPU     = 2'b10,
    TGT_SOC_ALT = 2'b11
  } rst_tgt_e;

  // packed MSB first: boot_sec is bit 7, enable is bit 0
  typedef struct packed {
    logic     boot_sec;
    rst_tgt_e tgt;
    logic     tick_1m;
    logic     ext_en;
    logic     irq_en;
    logic     rst_en;
    logic     enable;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned STAT_W = 3;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned      CNT_W   = 32,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic step, at_zero;

  assign step    = en_i & tick_i;
  assign at_zero = (cnt_q == '0);
  // restart has priority over an expiry in the same cycle
  assign tmo_o   = step & at_zero & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= RST_VAL;
    else if (restart_i) cnt_q <= reload_i;
    else if (step)      cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned      CNT_W      = 32,
  parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [CNT_W-1:0]  reload_o,
  output ctrl_t             ctrl_o,
  output logic              restart_o,
  output logic              clear_o
);
  logic [CNT_W-1:0] reload_q;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RST_RELOAD;
      ctrl_q   <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
      if (addr_i == OFS_CTRL)   ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  assign restart_o = we_i && (addr_i == OFS_RESTART) && (wdata_i == RESTART_KEY);
  assign clear_o   = we_i && (addr_i == OFS_CLEAR) && wdata_i[0];

  always_comb begin
    unique case (addr_i)
      OFS_COUNT:  rdata_o = DATA_W'(cnt_i);
      OFS_RELOAD: rdata_o = DATA_W'(reload_q);
      OFS_CTRL:   rdata_o = DATA_W'(ctrl_q);
      OFS_STATUS: rdata_o = DATA_W'(status_i);
      default:    rdata_o = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/wdt_cs_swap.sv
module wdt_cs_swap (
  input  logic swap_i,
  input  logic cs0_n_i,
  input  logic cs1_n_i,
  output logic cs0_n_o,
  output logic cs1_n_o
);
  assign cs0_n_o = swap_i ? cs1_n_i : cs0_n_i;
  assign cs1_n_o = swap_i ? cs0_n_i : cs1_n_i;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned      CNT_W      = 32,
  parameter int unsigned      CLK_DIV    = 100,
  parameter logic [CNT_W-1:0] RST_RELOAD = 32'h00FF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              rst_soc_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic              ext_req_o,
  input  logic              cs0_n_i,
  input  logic              cs1_n_i,
  output logic              cs0_n_o,
  output logic              cs1_n_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             restart, clear, presc_tick, tick_sel, tmo_evt;
  logic             tmo_flag_q, boot_sec_q, irq_q;
  logic             soc_q, chip_q, cpu_q, ext_q;
  logic             sel_soc, sel_chip, sel_cpu;

  wdt_regs #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_regs (
    .clk_i, .rst_ni,
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .cnt_i    (cnt_q),
    .status_i ({irq_q, boot_sec_q, tmo_flag_q}),
    .reload_o (reload_q),
    .ctrl_o   (ctrl_q),
    .restart_o(restart),
    .clear_o  (clear)
  );

  wdt_prescaler #(.DIV(CLK_DIV)) u_presc (
    .clk_i, .rst_ni, .tick_o(presc_tick)
  );

  assign tick_sel = ctrl_q.tick_1m ? presc_tick : 1'b1;

  wdt_counter #(.CNT_W(CNT_W), .RST_VAL(RST_RELOAD)) u_cnt (
    .clk_i, .rst_ni,
    .en_i     (ctrl_q.enable),
    .tick_i   (tick_sel),
    .restart_i(restart),
    .reload_i (reload_q),
    .cnt_o    (cnt_q),
    .tmo_o    (tmo_evt)
  );

  always_comb begin
    sel_soc  = 1'b0;
    sel_chip = 1'b0;
    sel_cpu  = 1'b0;
    unique case (ctrl_q.tgt)
      TGT_CHIP: sel_chip = 1'b1;
      TGT_CPU:  sel_cpu  = 1'b1;
      default:  sel_soc  = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soc_q  <= 1'b0;
      chip_q <= 1'b0;
      cpu_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      soc_q  <= tmo_evt & ctrl_q.rst_en & sel_soc;
      chip_q <= tmo_evt & ctrl_q.rst_en & sel_chip;
      cpu_q  <= tmo_evt & ctrl_q.rst_en & sel_cpu;
      ext_q  <= tmo_evt & ctrl_q.ext_en;
    end
  end

  // a timeout in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_flag_q <= 1'b0;
      boot_sec_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (tmo_evt)    tmo_flag_q <= 1'b1;
      else if (clear) tmo_flag_q <= 1'b0;
      if (tmo_evt && ctrl_q.boot_sec) boot_sec_q <= 1'b1;
      else if (clear)                 boot_sec_q <= 1'b0;
      if (tmo_evt && ctrl_q.irq_en)   irq_q <= 1'b1;
      else if (clear)                 irq_q <= 1'b0;
    end
  end

  wdt_cs_swap u_swap (
    .swap_i (boot_sec_q),
    .cs0_n_i, .cs1_n_i, .cs0_n_o, .cs1_n_o
  );

  assign irq_o      = irq_q;
  assign rst_soc_o  = soc_q;
  assign rst_chip_o = chip_q;
  assign rst_cpu_o  = cpu_q;
  assign ext_req_o  = ext_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [7:0]        ctrl_bits,
  input logic              tmo_evt,
  input logic              boot_sec_q,
  input logic              irq_o,
  input logic              rst_soc_o,
  input logic              rst_chip_o,
  input logic              rst_cpu_o,
  input logic              ext_req_o,
  input logic              cs0_n_i,
  input logic              cs1_n_i,
  input logic              cs0_n_o,
  input logic              cs1_n_o
);
  logic key_wr, clr_wr;
  assign key_wr = bus_we_i && bus_addr_i == 8'h08 && bus_wdata_i == 32'h4755;
  assign clr_wr = bus_we_i && bus_addr_i == 8'h14 && bus_wdata_i[0];

  p_restart_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> cnt_q == $past(reload_q));

  p_strobe_from_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_soc_o || rst_chip_o || rst_cpu_o || ext_req_o) |-> $past(cnt_q) == '0);

  p_one_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_soc_o, rst_chip_o, rst_cpu_o}));

  p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);

  p_swap_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_sec_q |-> (cs0_n_o == cs1_n_i && cs1_n_o == cs0_n_i));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !tmo_evt) |=> (!boot_sec_q && !irq_o));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_bits[0] && !key_wr) |=> $stable(cnt_q));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .bus_addr_i, .bus_we_i, .bus_wdata_i,
  .cnt_q, .reload_q, .ctrl_bits(ctrl_q), .tmo_evt, .boot_sec_q,
  .irq_o, .rst_soc_o, .rst_chip_o, .rst_cpu_o, .ext_req_o,
  .cs0_n_i, .cs1_n_i, .cs0_n_o, .cs1_n_o
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam int unsigned DIV = 4;
  localparam logic [31:0] RST_RL = 32'h00FF_FFFF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, soc, chip, cpu, ext;
  logic        cs0_i = 1'b0, cs1_i = 1'b1, cs0_o, cs1_o;
  int          vecs = 0, errs = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdt_keyed #(.CNT_W(32), .CLK_DIV(DIV), .RST_RELOAD(RST_RL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq),
    .rst_soc_o(soc), .rst_chip_o(chip), .rst_cpu_o(cpu), .ext_req_o(ext),
    .cs0_n_i(cs0_i), .cs1_n_i(cs1_i), .cs0_n_o(cs0_o), .cs1_n_o(cs1_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cs_sweep(input bit swapped, input string tag);
    for (int p = 0; p < 4; p++) begin
      cs0_i = p[0]; cs1_i = p[1]; #1;
      chk({cs0_o, cs1_o} == (swapped ? {cs1_i, cs0_i} : {cs0_i, cs1_i}), tag,
          {30'd0, cs0_o, cs1_o}, swapped ? {30'd0, cs1_i, cs0_i} : {30'd0, cs0_i, cs1_i});
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk(v == RST_RL, "R1 counter", v, RST_RL);
    rd(8'h04, v); chk(v == RST_RL, "R1 reload", v, RST_RL);
    rd(8'h0C, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(8'h10, v); chk(v == 0, "R1 status", v, 0);
    chk({irq, soc, chip, cpu, ext} == 0, "R1 strobes", {27'd0, irq, soc, chip, cpu, ext}, 0);
    cs_sweep(1'b0, "R1 cs");

    // R10 map and read-only counter
    rd(8'h18, v); chk(v == 0, "R10 unmapped", v, 0);
    wr(8'h0C, 32'hFFFF_FF80); rd(8'h0C, v); chk(v == 32'h80, "R10 ctrl width", v, 32'h80);
    wr(8'h0C, 0);
    wr(8'h00, 32'h1234); rd(8'h00, v); chk(v == RST_RL, "R10 count ro", v, RST_RL);

    // R2 restart key
    wr(8'h04, 50);
    rd(8'h04, v); chk(v == 50, "R10 reload rb", v, 50);
    foreach (v2[i]) begin end
    begin
      logic [31:0] bad [5];
      bad = '{32'h4754, 32'h0001_4755, 32'h4756, 32'h0, 32'h5547};
      foreach (bad[i]) begin
        wr(8'h08, bad[i]); rd(8'h00, v);
        chk(v == RST_RL, "R2 wrong key", v, RST_RL);
      end
    end
    wr(8'h08, 32'h4755); rd(8'h00, v); chk(v == 50, "R2 key load", v, 50);

    // R3 timeout timing, reload sweep
    for (int n = 0; n < 8; n++) begin
      int first;
      wr(8'h04, n); wr(8'h08, 32'h4755);
      wr(8'h0C, 32'h03);
      first = -1;
      for (int c = 1; c <= n + 3; c++) begin
        @(posedge clk); #1;
        if (soc && first < 0) first = c;
        if (first > 0 && c == first + 1 && n > 0)
          chk(!soc, "R3 pulse width", {31'd0, soc}, 0);
      end
      wr(8'h0C, 0);
      chk(first == n + 1, "R3 timeout cycle", first, n + 1);
    end

    // R4 target select and external request
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int x = 0; x < 2; x++) begin
          logic [3:0] exp;
          wr(8'h04, 2); wr(8'h08, 32'h4755);
          wr(8'h0C, 32'(1 | (e << 1) | (x << 3) | (m << 5)));
          repeat (3) @(posedge clk); #1;
          exp = {e == 1 && (m == 0 || m == 3), e == 1 && m == 1, e == 1 && m == 2, x == 1};
          chk({soc, chip, cpu, ext} == exp, "R4 strobes", {soc, chip, cpu, ext}, exp);
          wr(8'h0C, 0);
        end
    wr(8'h14, 1);

    // R5 sticky interrupt
    chk(!irq, "R5 irq idle", irq, 0);
    wr(8'h04, 1); wr(8'h08, 32'h4755); wr(8'h0C, 32'h05);
    repeat (4) @(posedge clk); wr(8'h0C, 0);
    repeat (10) @(posedge clk); #1;
    chk(irq, "R5 irq held", irq, 1);
    rd(8'h10, v); chk(v == 32'h5, "R5 status", v, 32'h5);
    wr(8'h14, 1); #1; chk(!irq, "R5 irq cleared", irq, 0);

    // R6/R7 alternate-boot swap
    wr(8'h04, 1); wr(8'h08, 32'h4755); wr(8'h0C, 32'h81);
    repeat (3) @(posedge clk); wr(8'h0C, 0);
    rd(8'h10, v); chk(v == 32'h3, "R6 status", v, 32'h3);
    cs_sweep(1'b1, "R6 swapped");
    wr(8'h14, 32'hFFFF_FFFE);
    rd(8'h10, v); chk(v == 32'h3, "R7 no-bit0 clear", v, 32'h3);
    cs_sweep(1'b1, "R7 still swapped");
    wr(8'h14, 1);
    rd(8'h10, v); chk(v == 0, "R7 cleared", v, 0);
    cs_sweep(1'b0, "R7 normal map");
    wr(8'h04, 1); wr(8'h08, 32'h4755); wr(8'h0C, 32'h01);
    repeat (3) @(posedge clk); wr(8'h0C, 0);
    rd(8'h10, v); chk(v == 32'h1, "R6 no arm", v, 32'h1);
    cs_sweep(1'b0, "R6 no swap");
    wr(8'h14, 1);

    // R8 freeze and resume
    wr(8'h04, 1000); wr(8'h08, 32'h4755); wr(8'h0C, 32'h01);
    repeat (10) @(posedge clk);
    wr(8'h0C, 0); rd(8'h00, v);
    repeat (20) @(negedge clk);
    rd(8'h00, v2); chk(v2 == v, "R8 frozen", v2, v);
    wr(8'h0C, 32'h01);
    repeat (5) @(posedge clk); #1;
    rd(8'h00, v2); chk(v2 == v - 5, "R8 resume", v2, v - 5);
    wr(8'h08, 32'h4755); rd(8'h00, v2); chk(v2 == 1000, "R2 restart running", v2, 1000);
    wr(8'h0C, 0);

    // R9 tick source
    for (int k = 1; k <= 5; k++) begin
      wr(8'h08, 32'h4755); wr(8'h0C, 32'h11);
      @(negedge clk); rd(8'h00, v);
      repeat (DIV * k) @(negedge clk);
      rd(8'h00, v2); chk(v - v2 == k, "R9 prescaled", v - v2, k);
      wr(8'h0C, 32'h01);
      @(negedge clk); rd(8'h00, v);
      repeat (k) @(negedge clk);
      rd(8'h00, v2); chk(v - v2 == k, "R9 per clock", v - v2, k);
      wr(8'h0C, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule